// File: doc/BRIEF.md
# Weighted Four-Class Descriptor Queue Scheduler

This block buffers fixed-size packet descriptors bound for a single output stream and decides which one leaves next. Each descriptor is 128 bits wide and carries a packet start pointer, a few early cell offsets, a next-hop identifier and control bits. Its two lowest control bits choose one of four class queues. Each queue is a 16-entry FIFO.

Congestion is handled at the input and never by back-pressure. The input is always ready. For every arrival, the block updates a smoothed (exponentially averaged) depth for the target queue. It then decides whether to drop the descriptor:
- A full queue always drops.
- An average at or above the upper threshold always drops.
- Between the lower and upper thresholds, the block drops with a probability that rises linearly with the excess. An 8-bit LFSR supplies the random value.

Each dropped arrival produces a one-cycle pulse that carries its class.

On the output side, a credit-based weighted round-robin arbiter serves the non-empty queues. A queue may send up to its weight in consecutive descriptors. The arbiter then moves on to the next index. When no non-empty queue has credit left, all credits reload from the configured weights.

Top module: `class_queue_sched`

## Requirements
- R1: The queue of an arrival is `in_desc[1:0]` (class 0 to 3). Descriptors of one class leave in the order they were accepted.
- R2: `in_ready` is 1 whenever reset is released. Every arrival is either queued or dropped.
- R3: Each queue holds a credit count. Every dequeue from a queue costs one credit. The arbiter keeps serving the current queue while it is non-empty and has credit. When that queue's credit reaches 0, the search point moves to the next higher index, wrapping from 3 to 0.
- R4: A queue that is empty is skipped, even if it has credit left. With all queues empty, `out_valid` is 0.
- R5: When some queue is non-empty but no non-empty queue has credit, every credit is loaded with its weight in one cycle, and `out_valid` is 0 in that cycle. A weight of 0 loads as 1. Weight i is `cfg_weight[4i+3:4i]`. Credits and the search point are 0 after reset.
- R6: An arrival to a queue that already holds 16 descriptors is dropped.
- R7: On each arrival to queue q, the smoothed depth is updated before the drop decision as avg ← avg + ((16·depth − avg) >>> 2). Here depth is the queue's fill before the arrival, avg has 4 fraction bits, and avg is 0 after reset. Departures do not change avg.
- R8: An arrival is dropped when the integer part of the updated avg (avg >> 4) is at least `cfg_max_th`.
- R9: Let excess = avg − 16·`cfg_min_th`. If excess ≤ 0, the early-drop stage never drops. Otherwise the arrival is dropped when (excess << `cfg_slope`) exceeds the current 8-bit random value, so a shifted excess of 256 or more always drops.
- R10: One cycle after a dropped arrival, `drop_pulse` is 1 for one cycle and `drop_class` holds that arrival's class. An accepted arrival raises no pulse.
- R11: Directly after reset, `out_valid` and `drop_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Arriving descriptor present |
| in_ready | output | 1 | Always high out of reset |
| in_desc | input | 128 | Arriving descriptor; bits [1:0] select the class |
| cfg_weight | input | 16 | Four 4-bit per-class weights |
| cfg_min_th | input | 5 | Lower smoothed-depth threshold (entries) |
| cfg_max_th | input | 5 | Upper smoothed-depth threshold (entries) |
| cfg_slope | input | 4 | Left shift applied to the excess before the random compare |
| out_valid | output | 1 | Selected descriptor present |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_desc | output | 128 | Selected descriptor |
| drop_pulse | output | 1 | An arrival was dropped one cycle earlier |
| drop_class | output | 2 | Class of the dropped arrival |

## Verification
Any fault in a queue's pointers or fill count shows up at the next drain: the scoreboard then sees a descriptor in the wrong order, a duplicate or a missing entry. A fault in the credit state changes the class sequence within one weighted round. A fault in the smoothed depth shifts the arrival at which drops begin. Because every arrival is compared with a predicted drop bit one cycle later, such an error is caught at the first affected arrival. The drop scenarios are arranged so that each prediction falls where the random value cannot change the outcome.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

    localparam int RND_W = 8;
    typedef logic [RND_W-1:0] rnd_t;

    // Galois LFSR step, maximal length for 8 bits
    function automatic rnd_t rnd_step(rnd_t cur);
        rnd_t nxt;
        nxt = cur >> 1;
        if (cur[0]) nxt = nxt ^ 8'hB8;
        return nxt;
    endfunction

    localparam rnd_t RND_SEED = 8'h5A;

endpackage

// File: rtl/cqs_fifo.sv
module cqs_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        end
        if (push && !pop)      st_d.cnt = st_q.cnt + CW'(1);
        else if (pop && !push) st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

endmodule

// File: rtl/cqs_red.sv
module cqs_red
    import cqs_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int DEPTH    = 16,
    parameter int FRAC     = 4,
    parameter int EW_SHIFT = 2,
    parameter int TH_W     = 5,
    parameter int SL_W     = 4,
    localparam int CLS_W   = $clog2(NQ),
    localparam int CNT_W   = $clog2(DEPTH) + 1,
    localparam int AVG_W   = CNT_W + FRAC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arrive,
    input  logic [CLS_W-1:0]    cls,
    input  logic [NQ*CNT_W-1:0] depth_flat,
    input  logic [TH_W-1:0]     min_th,
    input  logic [TH_W-1:0]     max_th,
    input  logic [SL_W-1:0]     slope,
    output logic                drop
);

    typedef struct packed {
        logic [NQ-1:0][AVG_W-1:0] avg;
        rnd_t                     lfsr;
    } red_st_t;

    red_st_t st_d, st_q;

    logic [CNT_W-1:0]        depth;
    logic signed [AVG_W+1:0] diff;
    logic signed [AVG_W+1:0] sum;
    logic [AVG_W-1:0]        avg_new;
    logic [31:0]             avg_int;
    logic signed [33:0]      excess;
    logic [63:0]             scaled;
    logic                    is_full;
    logic                    over_max;
    logic                    rnd_hit;

    always_comb begin
        st_d      = st_q;
        st_d.lfsr = rnd_step(st_q.lfsr);

        depth   = depth_flat[cls*CNT_W +: CNT_W];
        diff    = $signed({2'b00, depth, {FRAC{1'b0}}}) - $signed({2'b00, st_q.avg[cls]});
        sum     = $signed({2'b00, st_q.avg[cls]}) + (diff >>> EW_SHIFT);
        avg_new = sum[AVG_W-1:0];
        avg_int = 32'(avg_new >> FRAC);

        excess  = $signed({2'b00, 32'(avg_new)}) - $signed({2'b00, 32'(min_th) << FRAC});
        scaled  = 64'(excess[31:0]) << slope;

        is_full  = (32'(depth) >= DEPTH);
        over_max = (avg_int >= 32'(max_th));
        rnd_hit  = (excess > 0) && (scaled > 64'(st_q.lfsr));

        drop = arrive && (is_full || over_max || rnd_hit);

        if (arrive) st_d.avg[cls] = avg_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.avg  <= '0;
            st_q.lfsr <= RND_SEED;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cqs_wrr.sv
module cqs_wrr #(
    parameter int NQ   = 4,
    parameter int WW   = 4,
    localparam int IW  = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    nonempty,
    input  logic [NQ*WW-1:0] weight_flat,
    input  logic             deq,
    output logic [IW-1:0]    sel,
    output logic             sel_valid
);

    typedef struct packed {
        logic [NQ-1:0][WW-1:0] credit;
        logic [IW-1:0]         cur;
    } wrr_st_t;

    wrr_st_t st_d, st_q;

    logic          found;
    logic [IW-1:0] pick;
    int            j;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        pick  = '0;
        j     = 0;
        for (int k = 0; k < NQ; k++) begin
            j = int'(st_q.cur) + k;
            if (j >= NQ) j = j - NQ;
            if (!found && nonempty[j] && (st_q.credit[j] != '0)) begin
                found = 1'b1;
                pick  = IW'(j);
            end
        end

        if (found && deq) begin
            st_d.credit[pick] = st_q.credit[pick] - WW'(1);
            if (st_q.credit[pick] == WW'(1))
                st_d.cur = (pick == IW'(NQ - 1)) ? '0 : pick + IW'(1);
            else
                st_d.cur = pick;
        end else if (!found && (|nonempty)) begin
            for (int i = 0; i < NQ; i++) begin
                st_d.credit[i] = (weight_flat[i*WW +: WW] == '0) ? WW'(1)
                                                                 : weight_flat[i*WW +: WW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel       = pick;
    assign sel_valid = found;

endmodule

// File: rtl/class_queue_sched.sv
module class_queue_sched #(
    parameter int DESC_W   = 128,
    parameter int NQ       = 4,
    parameter int DEPTH    = 16,
    parameter int WW       = 4,
    parameter int TH_W     = 5,
    parameter int SL_W     = 4,
    parameter int FRAC     = 4,
    parameter int EW_SHIFT = 2,
    localparam int CLS_W   = $clog2(NQ),
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DESC_W-1:0] in_desc,
    input  logic [NQ*WW-1:0]  cfg_weight,
    input  logic [TH_W-1:0]   cfg_min_th,
    input  logic [TH_W-1:0]   cfg_max_th,
    input  logic [SL_W-1:0]   cfg_slope,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DESC_W-1:0] out_desc,
    output logic              drop_pulse,
    output logic [CLS_W-1:0]  drop_class
);

    typedef struct packed {
        logic             pulse;
        logic [CLS_W-1:0] cls;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                arrive;
    logic                drop;
    logic [CLS_W-1:0]    in_cls;
    logic [CLS_W-1:0]    sel;
    logic                deq;
    logic [NQ-1:0]       q_nonempty;
    logic [NQ*CNT_W-1:0] q_count_flat;
    logic [DESC_W-1:0]   q_dout [NQ];

    assign in_ready = 1'b1;
    assign arrive   = in_valid;
    assign in_cls   = in_desc[CLS_W-1:0];
    assign deq      = out_valid && out_ready;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic [CNT_W-1:0] cnt;
        logic             push_g;
        logic             pop_g;

        assign push_g = arrive && !drop && (in_cls == CLS_W'(g));
        assign pop_g  = deq && (sel == CLS_W'(g));

        cqs_fifo #(
            .W     (DESC_W),
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_g),
            .din   (in_desc),
            .pop   (pop_g),
            .dout  (q_dout[g]),
            .count (cnt)
        );

        assign q_count_flat[g*CNT_W +: CNT_W] = cnt;
        assign q_nonempty[g] = (cnt != '0);
    end

    cqs_red #(
        .NQ       (NQ),
        .DEPTH    (DEPTH),
        .FRAC     (FRAC),
        .EW_SHIFT (EW_SHIFT),
        .TH_W     (TH_W),
        .SL_W     (SL_W)
    ) u_red (
        .clk        (clk),
        .rst_n      (rst_n),
        .arrive     (arrive),
        .cls        (in_cls),
        .depth_flat (q_count_flat),
        .min_th     (cfg_min_th),
        .max_th     (cfg_max_th),
        .slope      (cfg_slope),
        .drop       (drop)
    );

    cqs_wrr #(
        .NQ (NQ),
        .WW (WW)
    ) u_wrr (
        .clk         (clk),
        .rst_n       (rst_n),
        .nonempty    (q_nonempty),
        .weight_flat (cfg_weight),
        .deq         (deq),
        .sel         (sel),
        .sel_valid   (out_valid)
    );

    assign out_desc = q_dout[sel];

    always_comb begin
        st_d       = st_q;
        st_d.pulse = drop;
        st_d.cls   = drop ? in_cls : st_q.cls;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drop_pulse = st_q.pulse;
    assign drop_class = st_q.cls;

endmodule

// File: rtl/cqs_chk.sv
module cqs_chk #(
    parameter int NQ    = 4,
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int CLS_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [CLS_W-1:0]    in_cls,
    input logic                drop_pulse,
    input logic [CLS_W-1:0]    drop_class,
    input logic                out_valid,
    input logic [CLS_W-1:0]    sel,
    input logic [NQ-1:0]       q_nonempty,
    input logic [NQ*CNT_W-1:0] q_count_flat
);

    // R10
    drop_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> ($past(in_valid) && (drop_class == $past(in_cls))));

    // R3
    sel_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> q_nonempty[sel]);

    // R4
    idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_nonempty == '0) |-> !out_valid);

    // R5
    reload_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && (q_nonempty != '0)) |=> out_valid);

    for (genvar g = 0; g < NQ; g++) begin : g_bound
        // R6
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            32'(q_count_flat[g*CNT_W +: CNT_W]) <= DEPTH);
    end

endmodule

bind class_queue_sched cqs_chk #(
    .NQ    (NQ),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .CLS_W (CLS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_cls       (in_cls),
    .drop_pulse   (drop_pulse),
    .drop_class   (drop_class),
    .out_valid    (out_valid),
    .sel          (sel),
    .q_nonempty   (q_nonempty),
    .q_count_flat (q_count_flat)
);

// File: tb/tb_class_queue_sched.sv
`timescale 1ns/1ps
module tb_class_queue_sched;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_desc = '0;
    logic [15:0]  cfg_weight = 16'h1111;
    logic [4:0]   cfg_min_th = 5'd31;
    logic [4:0]   cfg_max_th = 5'd31;
    logic [3:0]   cfg_slope = 4'd0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_desc;
    logic         drop_pulse;
    logic [1:0]   drop_class;

    always #10 clk = ~clk;

    class_queue_sched dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .cfg_weight(cfg_weight), .cfg_min_th(cfg_min_th),
        .cfg_max_th(cfg_max_th), .cfg_slope(cfg_slope), .out_valid(out_valid),
        .out_ready(out_ready), .out_desc(out_desc), .drop_pulse(drop_pulse),
        .drop_class(drop_class)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model of the requirements
    logic [127:0] mq [4][$];
    logic [127:0] exp_q [$];
    int cred [4] = '{0, 0, 0, 0};
    int cur = 0;
    int avg [4] = '{0, 0, 0, 0};
    int tag = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [127:0] mk(input int t, input int c);
        return {32'(t), ~32'(t), 32'(t) ^ 32'hA5A5_5A5A, 30'(t), 2'(c)};
    endfunction

    // R7 R8 R9 R6: predicted drop decision, updates the smoothed depth model
    function automatic int predict(input int c);
        int d, a, ex;
        d = mq[c].size();
        a = avg[c] + ((d * 16 - avg[c]) >>> 2);
        avg[c] = a;
        if (d >= 16) return 1;
        if ((a >>> 4) >= int'(cfg_max_th)) return 1;
        ex = a - int'(cfg_min_th) * 16;
        if (ex <= 0) return 0;
        if ((ex << cfg_slope) >= 256) return 1;
        return 2;
    endfunction

    task automatic send(input int c, input string req);
        logic [127:0] dsc;
        int p;
        dsc = mk(tag, c);
        tag++;
        p = predict(c);
        @(posedge clk); #1;
        chk(in_ready == 1'b1, "R2", "in_ready", 128'(in_ready), 128'd1);
        in_valid = 1'b1;
        in_desc  = dsc;
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        chk(p != 2, req, "prediction outside deterministic region", 128'(p), 128'd0);
        chk(drop_pulse == (p == 1), req, "drop_pulse", 128'(drop_pulse), 128'(p == 1));
        if (p == 1)
            chk(drop_class == 2'(c), "R10", "drop_class", 128'(drop_class), 128'(c));
        if (p == 0) mq[c].push_back(dsc);
    endtask

    // R3 R4 R5: expected service order from the credit rule
    task automatic drain();
        int found, w, guard;
        forever begin
            if (mq[0].size() + mq[1].size() + mq[2].size() + mq[3].size() == 0) break;
            found = -1;
            for (int k = 0; k < 4; k++) begin
                int jj;
                jj = (cur + k) % 4;
                if (found < 0 && mq[jj].size() > 0 && cred[jj] > 0) found = jj;
            end
            if (found < 0) begin
                for (int i = 0; i < 4; i++) begin
                    w = int'(cfg_weight[i*4 +: 4]);
                    cred[i] = (w == 0) ? 1 : w;
                end
            end else begin
                exp_q.push_back(mq[found].pop_front());
                cred[found]--;
                cur = (cred[found] == 0) ? (found + 1) % 4 : found;
            end
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        guard = 0;
        while (exp_q.size() > 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk); #1;
        out_ready = 1'b0;
        chk(exp_q.size() == 0, "R3", "items left undelivered", 128'(exp_q.size()), 128'd0);
        exp_q.delete();
        @(negedge clk);
        chk(out_valid == 1'b0, "R4", "out_valid after drain", 128'(out_valid), 128'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected descriptor", out_desc, 128'd0);
            end else begin
                logic [127:0] e;
                e = exp_q.pop_front();
                chk(out_desc == e, "R1 R3", "order", out_desc, e);
            end
        end
    end

    initial begin
        #(200000 * 20);
        chk(1'b0, "watchdog", "run did not finish", 128'd0, 128'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid in reset", 128'(out_valid), 128'd0);
        chk(drop_pulse == 1'b0, "R11", "drop_pulse in reset", 128'(drop_pulse), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", 128'(out_valid), 128'd0);
        chk(drop_pulse == 1'b0, "R11", "drop_pulse after reset", 128'(drop_pulse), 128'd0);
        chk(in_ready == 1'b1, "R2", "in_ready after reset", 128'(in_ready), 128'd1);

        // R1: class routing and per-class order
        for (int i = 0; i < 5; i++) begin
            send(2, "R1");
            if (i < 3) send(0, "R1");
        end
        drain();

        // R3: weights 3,1,2,1 with every queue loaded
        cfg_weight = {4'd1, 4'd2, 4'd1, 4'd3};
        for (int i = 0; i < 4; i++)
            for (int c = 0; c < 4; c++) send(c, "R3");
        drain();

        // R4: class 1 stays empty
        for (int i = 0; i < 3; i++) begin
            send(0, "R4"); send(2, "R4"); send(3, "R4");
        end
        drain();

        // R5: zero weights load as one
        cfg_weight = {4'd1, 4'd0, 4'd2, 4'd0};
        for (int i = 0; i < 3; i++) begin
            send(0, "R5"); send(1, "R5"); send(3, "R5");
        end
        drain();

        // R6 R10: overfill class 1
        for (int i = 0; i < 20; i++) send(1, "R6");
        drain();

        // R8 R7: low upper threshold on class 3
        cfg_min_th = 5'd31;
        cfg_max_th = 5'd2;
        for (int i = 0; i < 10; i++) send(3, "R8");
        drain();

        // R9 R7: early-drop region with saturated slope on class 0
        cfg_min_th = 5'd1;
        cfg_max_th = 5'd31;
        cfg_slope  = 4'd8;
        for (int i = 0; i < 12; i++) send(0, "R9");
        drain();

        finish_run();
    end

endmodule